// File: doc/BRIEF.md
# PCI Configuration Access Router

This block sits between a host I/O port and the targets of PCI configuration cycles. It follows configuration Mechanism #1. The host first writes a dword to a configuration address register. It then reads or writes a four-byte data window. The block turns each window access into one request on exactly one of three target ports, using the bus, device, function and register fields held in the latched address.

There are three target ports. The first is an internal register port for the on-chip devices of bus 0. The second is a bridged secondary port for the bus-number range behind an internal bridge. The third is a downstream hub port. Hub requests carry either a plain I/O cycle or a configuration cycle of Type 0 or Type 1.

Every host access is held until the block pulses `host_ready`. A target request is held until that target answers with its own ready. Host I/O addresses other than the two register dwords are passed to the hub port as plain I/O cycles.

Top module: `cfg_access_router`

## Requirements
- R1: After reset, `host_ready` and all three target requests are 0, and a read of the address register (dword 0xCF8) returns 0.
- R2: A write to dword 0xCF8 with all four byte enables set loads the address register. A later read of 0xCF8 returns the written value with bits 30:24 and 1:0 forced to 0. The fields are: enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:2.
- R3: A write to dword 0xCF8 with any byte enable clear completes on the host port. It leaves the address register unchanged and raises no target request.
- R4: When enable is 0, an access to dword 0xCFC goes to the hub port as a plain I/O cycle. In that cycle `hub_cfg` is 0 and `tgt_addr` is 0x0000_0CFC.
- R5: When enable is 1, bus is 0 and the device is an enabled internal device (below NUM_DEV, with its `dev_en` bit set), the access goes only to the internal port. `tgt_addr` is {8'h00, bus, device, function, register, 2'b00}.
- R6: Device 0 on bus 0 is always internal, whatever the value of `dev_en[0]`.
- R7: A bus-0 configuration access goes to the hub port with `hub_cfg` = 1 and `hub_type1` = 0 in two cases: the device is an internal device whose enable bit is clear, or the device number is NUM_DEV or higher.
- R8: A configuration access with a nonzero bus in the range `sec_bus` to `sub_bus`, inclusive, goes to the secondary port. `sec_type1` is 0 when bus equals `sec_bus` and 1 otherwise.
- R9: A configuration access to any other nonzero bus goes to the hub port with `hub_cfg` = 1 and `hub_type1` = 1.
- R10: A routed access completes only after the chosen target asserts its ready. `host_ready` pulses for one cycle, on the cycle after that target ready. A read returns the chosen target's `*_rdata`, and a write returns 0. Byte enables, write flag and write data reach the target unchanged.
- R11: At most one target request is high at a time. A request, and with it `tgt_addr`, stays stable until that target answers.
- R12: A host access to any dword other than 0xCF8 and 0xCFC goes to the hub as a plain I/O cycle, with `tgt_addr` = {16'h0, dword address, 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Host I/O dword address (byte address bits 15:2) |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| dev_en | input | NUM_DEV | Enable per internal bus-0 device |
| sec_bus | input | 8 | Lowest bus number behind the bridge |
| sub_bus | input | 8 | Highest bus number behind the bridge |
| tgt_addr | output | 32 | Configuration or I/O address sent to the selected target |
| tgt_be | output | 4 | Byte enables sent to the target |
| tgt_we | output | 1 | Write flag sent to the target |
| tgt_wdata | output | 32 | Write data sent to the target |
| int_req | output | 1 | Internal register port request |
| int_ready | input | 1 | Internal port completion |
| int_rdata | input | 32 | Internal port read data |
| sec_req | output | 1 | Secondary port request |
| sec_type1 | output | 1 | Secondary request is Type 1 |
| sec_ready | input | 1 | Secondary port completion |
| sec_rdata | input | 32 | Secondary port read data |
| hub_req | output | 1 | Hub port request |
| hub_cfg | output | 1 | Hub request is a configuration cycle (0 = plain I/O) |
| hub_type1 | output | 1 | Hub configuration cycle is Type 1 |
| hub_ready | input | 1 | Hub port completion |
| hub_rdata | input | 32 | Hub port read data |

## Verification
The hardest cases to reach from the ports are the routing boundaries. They depend on two separate host accesses lining up with the side inputs: a full dword write that sets the bus and device fields, then a later window access. In that window access the bus must sit exactly on `sec_bus`, on `sub_bus`, or one past the range, or the device must be a disabled internal device or device 0 with its enable bit clear. The stimulus reaches these cases by drawing bus numbers from a weighted set built around the current bridge window, by drawing devices on both sides of NUM_DEV, and by changing the window and the enable mask between accesses. Target latency is also randomised, so that a ready arriving late shows whether the held request stays stable.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  typedef enum logic [1:0] {
    TGT_LOCAL = 2'd0,
    TGT_INT   = 2'd1,
    TGT_SEC   = 2'd2,
    TGT_HUB   = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e        tgt;
    logic        cfg;
    logic        type1;
    logic [31:0] addr;
  } route_t;

  // dword addresses of the two host registers (byte 0xCF8 and 0xCFC)
  localparam logic [13:0] ADDR_DW = 14'h33E;
  localparam logic [13:0] DATA_DW = 14'h33F;

  // bits of the address register that are kept
  localparam logic [31:0] CFG_MASK = 32'h80FF_FFFC;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_sn,
  input  logic        load,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  logic [31:0] q_nxt;

  always_comb q_nxt = wdata & CFG_MASK;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)   q <= '0;
    else if (load) q <= q_nxt;
  end
endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
  import cfg_router_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic [31:0]        cfg_q,
  input  logic [13:0]        io_dw,
  input  logic [NUM_DEV-1:0] dev_en,
  input  logic [7:0]         sec_bus,
  input  logic [7:0]         sub_bus,
  output route_t             route
);
  localparam int DEV_W = 5;

  logic             cfg_on;
  logic [7:0]       bus;
  logic [DEV_W-1:0] dev;
  logic [NUM_DEV-1:0] hit_vec;
  logic             in_win;
  logic [31:0]      cfg_word;
  logic [31:0]      io_word;

  assign cfg_on   = cfg_q[31];
  assign bus      = cfg_q[23:16];
  assign dev      = cfg_q[15:11];
  assign cfg_word = {8'h00, cfg_q[23:0]};
  assign io_word  = {16'h0000, io_dw, 2'b00};
  assign in_win   = (bus >= sec_bus) && (bus <= sub_bus);

  // one compare per internal device; device 0 (host bridge) is never disabled
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    if (g == 0) begin : g_host
      assign hit_vec[g] = (dev == DEV_W'(g));
    end else begin : g_other
      assign hit_vec[g] = (dev == DEV_W'(g)) && dev_en[g];
    end
  end

  always_comb begin
    route.tgt   = TGT_HUB;
    route.cfg   = 1'b0;
    route.type1 = 1'b0;
    route.addr  = io_word;
    if (io_dw == ADDR_DW) begin
      route.tgt = TGT_LOCAL;
    end else if (io_dw == DATA_DW && cfg_on) begin
      route.addr = cfg_word;
      if (bus == 8'h00) begin
        if (|hit_vec) route.tgt = TGT_INT;
        else          route.cfg = 1'b1;
      end else if (in_win) begin
        route.tgt   = TGT_SEC;
        route.type1 = (bus != sec_bus);
      end else begin
        route.cfg   = 1'b1;
        route.type1 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_router_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [15:2]        host_addr,
  input  logic [3:0]         host_be,
  input  logic [31:0]        host_wdata,
  output logic               host_ready,
  output logic [31:0]        host_rdata,
  input  logic [NUM_DEV-1:0] dev_en,
  input  logic [7:0]         sec_bus,
  input  logic [7:0]         sub_bus,
  output logic [31:0]        tgt_addr,
  output logic [3:0]         tgt_be,
  output logic               tgt_we,
  output logic [31:0]        tgt_wdata,
  output logic               int_req,
  input  logic               int_ready,
  input  logic [31:0]        int_rdata,
  output logic               sec_req,
  output logic               sec_type1,
  input  logic               sec_ready,
  input  logic [31:0]        sec_rdata,
  output logic               hub_req,
  output logic               hub_cfg,
  output logic               hub_type1,
  input  logic               hub_ready,
  input  logic [31:0]        hub_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_e;

  logic        rst_sn;
  logic [31:0] cfg_q;
  logic        cfg_load;
  route_t      route;

  st_e         st_q, st_n;
  route_t      cur_q, cur_n;
  logic [3:0]  be_q, be_n;
  logic        we_q, we_n;
  logic [31:0] wd_q, wd_n;
  logic [31:0] rd_q, rd_n;
  logic        sel_ready;
  logic [31:0] sel_rdata;

  cfg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  cfg_addr_reg u_areg (
    .clk(clk), .rst_sn(rst_sn), .load(cfg_load), .wdata(host_wdata), .q(cfg_q)
  );

  cfg_route_decode #(.NUM_DEV(NUM_DEV)) u_dec (
    .cfg_q(cfg_q), .io_dw(host_addr), .dev_en(dev_en),
    .sec_bus(sec_bus), .sub_bus(sub_bus), .route(route)
  );

  always_comb begin
    sel_ready = 1'b0;
    sel_rdata = '0;
    unique case (cur_q.tgt)
      TGT_INT: begin sel_ready = int_ready; sel_rdata = int_rdata; end
      TGT_SEC: begin sel_ready = sec_ready; sel_rdata = sec_rdata; end
      TGT_HUB: begin sel_ready = hub_ready; sel_rdata = hub_rdata; end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_n     = st_q;
    cur_n    = cur_q;
    be_n     = be_q;
    we_n     = we_q;
    wd_n     = wd_q;
    rd_n     = rd_q;
    cfg_load = 1'b0;
    unique case (st_q)
      S_IDLE: if (host_req) begin
        cur_n = route;
        be_n  = host_be;
        we_n  = host_we;
        wd_n  = host_wdata;
        if (route.tgt == TGT_LOCAL) begin
          cfg_load = host_we && (&host_be);
          rd_n     = host_we ? '0 : cfg_q;
          st_n     = S_DONE;
        end else begin
          st_n = S_WAIT;
        end
      end
      S_WAIT: if (sel_ready) begin
        rd_n = we_q ? '0 : sel_rdata;
        st_n = S_DONE;
      end
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= S_IDLE;
      cur_q <= '0;
      be_q  <= '0;
      we_q  <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
      be_q  <= be_n;
      we_q  <= we_n;
      wd_q  <= wd_n;
      rd_q  <= rd_n;
    end
  end

  assign host_ready = (st_q == S_DONE);
  assign host_rdata = rd_q;
  assign tgt_addr   = cur_q.addr;
  assign tgt_be     = be_q;
  assign tgt_we     = we_q;
  assign tgt_wdata  = wd_q;
  assign int_req    = (st_q == S_WAIT) && (cur_q.tgt == TGT_INT);
  assign sec_req    = (st_q == S_WAIT) && (cur_q.tgt == TGT_SEC);
  assign hub_req    = (st_q == S_WAIT) && (cur_q.tgt == TGT_HUB);
  assign sec_type1  = cur_q.type1;
  assign hub_cfg    = cur_q.cfg;
  assign hub_type1  = cur_q.type1;
endmodule

// File: rtl/cfg_access_router_chk.sv
module cfg_access_router_chk #(
  parameter int NUM_DEV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_ready,
  input logic [7:0]  sec_bus,
  input logic [7:0]  sub_bus,
  input logic [31:0] tgt_addr,
  input logic        int_req,
  input logic        int_ready,
  input logic        sec_req,
  input logic        sec_type1,
  input logic        sec_ready,
  input logic        hub_req,
  input logic        hub_cfg,
  input logic        hub_type1,
  input logic        hub_ready
);
  logic [7:0] bus_o;
  logic [4:0] dev_o;
  logic       waiting;
  assign bus_o   = tgt_addr[23:16];
  assign dev_o   = tgt_addr[15:11];
  assign waiting = (int_req && !int_ready) || (sec_req && !sec_ready) ||
                   (hub_req && !hub_ready);

  a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_req, sec_req, hub_req}));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> $stable({int_req, sec_req, hub_req}) && $stable(tgt_addr));

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  a_r5_internal_bus0: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (bus_o == 8'h00) && (int'(dev_o) < NUM_DEV));

  a_r8_sec_window: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req |-> (bus_o >= sec_bus) && (bus_o <= sub_bus) && (bus_o != 8'h00)
                && (sec_type1 == (bus_o != sec_bus)));

  a_r7_hub_type0_bus0: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_req && hub_cfg && !hub_type1) |-> (bus_o == 8'h00));

  a_r9_hub_type1: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_req && hub_type1) |-> hub_cfg && (bus_o != 8'h00));

  a_r4_hub_io_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_req && !hub_cfg) |-> !hub_type1 && (tgt_addr[31:16] == 16'h0000));
endmodule

bind cfg_access_router cfg_access_router_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready),
  .sec_bus(sec_bus), .sub_bus(sub_bus), .tgt_addr(tgt_addr),
  .int_req(int_req), .int_ready(int_ready),
  .sec_req(sec_req), .sec_type1(sec_type1), .sec_ready(sec_ready),
  .hub_req(hub_req), .hub_cfg(hub_cfg), .hub_type1(hub_type1), .hub_ready(hub_ready)
);

// File: tb/test_cfg_access_router.sv
`timescale 1ns/1ps
module test_cfg_access_router;
  localparam int NUM_DEV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic host_req, host_we, host_ready;
  logic [15:0] host_byte_addr;
  logic [3:0]  host_be, tgt_be;
  logic [31:0] host_wdata, host_rdata, tgt_addr, tgt_wdata;
  logic [NUM_DEV-1:0] dev_en;
  logic [7:0] sec_bus, sub_bus;
  logic tgt_we, int_req, int_ready, sec_req, sec_type1, sec_ready;
  logic hub_req, hub_cfg, hub_type1, hub_ready;
  logic [31:0] int_rdata, sec_rdata, hub_rdata;

  always #2.5 clk = ~clk;

  cfg_access_router #(.NUM_DEV(NUM_DEV)) i_cfg_access_router (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_byte_addr[15:2]), .host_be(host_be), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata), .dev_en(dev_en),
    .sec_bus(sec_bus), .sub_bus(sub_bus), .tgt_addr(tgt_addr), .tgt_be(tgt_be),
    .tgt_we(tgt_we), .tgt_wdata(tgt_wdata), .int_req(int_req), .int_ready(int_ready),
    .int_rdata(int_rdata), .sec_req(sec_req), .sec_type1(sec_type1),
    .sec_ready(sec_ready), .sec_rdata(sec_rdata), .hub_req(hub_req),
    .hub_cfg(hub_cfg), .hub_type1(hub_type1), .hub_ready(hub_ready),
    .hub_rdata(hub_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] mdl_cfg;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected routing: tgt 0 local, 1 internal, 2 secondary, 3 hub
  function automatic void exp_route(input logic [15:0] ba, output int tgt,
      output bit cfg, output bit t1, output logic [31:0] addr, output string req);
    logic [7:0] bus = mdl_cfg[23:16];
    int dev = int'(mdl_cfg[15:11]);
    tgt = 3; cfg = 0; t1 = 0; addr = {16'h0, ba[15:2], 2'b00}; req = "R12";
    if (ba[15:2] == 14'h33E) begin tgt = 0; req = "R2"; end
    else if (ba[15:2] == 14'h33F) begin
      if (!mdl_cfg[31]) req = "R4";
      else begin
        addr = {8'h00, mdl_cfg[23:0]};
        if (bus == 0) begin
          if (dev == 0) begin tgt = 1; req = "R6"; end
          else if (dev < NUM_DEV && dev_en[dev]) begin tgt = 1; req = "R5"; end
          else begin cfg = 1; req = "R7"; end
        end else if (bus >= sec_bus && bus <= sub_bus) begin
          tgt = 2; t1 = (bus != sec_bus); req = "R8";
        end else begin cfg = 1; t1 = 1; req = "R9"; end
      end
    end
  endfunction

  task automatic access(input bit we, input logic [15:0] ba, input logic [3:0] be,
                        input logic [31:0] wd);
    int tgt, seen, lat, cnt;
    bit cfg, t1, gave, done;
    logic [31:0] ea, resp, erd;
    string req;
    exp_route(ba, tgt, cfg, t1, ea, req);
    erd = we ? 32'h0 : (tgt == 0 ? mdl_cfg : 32'h0);
    lat = $urandom_range(0, 3);
    seen = 0; cnt = 0; gave = 0; done = 0; resp = 0;
    @(negedge clk);
    host_req = 1; host_we = we; host_byte_addr = ba; host_be = be; host_wdata = wd;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      int_ready = 0; sec_ready = 0; hub_ready = 0;
      if (host_ready) begin done = 1; break; end
      if (!gave && (int_req || sec_req || hub_req)) begin
        if (seen == 0) begin
          seen = int_req ? 1 : (sec_req ? 2 : 3);
          chk(tgt_addr == ea, req, "target address", tgt_addr, ea);
          chk(tgt_be == be && tgt_we == we, "R10", "byte enables/write flag",
              {27'h0, tgt_we, tgt_be}, {27'h0, we, be});
          if (we) chk(tgt_wdata == wd, "R10", "write data", tgt_wdata, wd);
          if (seen == 2) chk(sec_type1 == t1, req, "secondary type1", sec_type1, t1);
          if (seen == 3) chk(hub_cfg == cfg && hub_type1 == t1, req, "hub cfg/type1",
                             {hub_cfg, hub_type1}, {cfg, t1});
        end
        if (cnt == lat) begin
          resp = $urandom;
          int_rdata = ~resp; sec_rdata = ~resp; hub_rdata = ~resp;
          if (seen == 1) begin int_ready = 1; int_rdata = resp; end
          if (seen == 2) begin sec_ready = 1; sec_rdata = resp; end
          if (seen == 3) begin hub_ready = 1; hub_rdata = resp; end
          gave = 1;
        end else cnt++;
      end
    end
    host_req = 0;
    chk(done, "R10", "host completion", {31'h0, done}, 32'h1);
    chk(seen == tgt, req, "selected target", seen, tgt);
    if (tgt != 0) begin
      chk(gave, "R10", "ready not before target ready", {31'h0, gave}, 32'h1);
      if (!we) erd = resp;
    end
    chk(host_rdata == erd, tgt == 0 ? req : "R10", "read data", host_rdata, erd);
    if (tgt == 0 && we && be == 4'hF) mdl_cfg = wd & 32'h80FF_FFFC;
  endtask

  task automatic set_cfg(input bit en, input logic [7:0] bus, input logic [4:0] dev,
                         input logic [2:0] fn, input logic [5:0] rg);
    access(1, 16'h0CF8, 4'hF, {en, 7'h5A, bus, dev, fn, rg, 2'b11});
  endtask

  function automatic logic [7:0] pick_bus();
    case ($urandom_range(0, 6))
      0, 1: return 8'h00;
      2: return sec_bus;
      3: return sub_bus;
      4: return sec_bus + 8'd1;
      5: return sub_bus + 8'd1;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd5150));
    rst_n = 0; host_req = 0; host_we = 0; host_byte_addr = 0; host_be = 0;
    host_wdata = 0; int_ready = 0; sec_ready = 0; hub_ready = 0;
    int_rdata = 0; sec_rdata = 0; hub_rdata = 0;
    dev_en = 4'b1010; sec_bus = 8'd2; sub_bus = 8'd5;
    mdl_cfg = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!host_ready && !int_req && !sec_req && !hub_req, "R1", "idle outputs after reset",
        {28'h0, host_ready, int_req, sec_req, hub_req}, 32'h0);
    access(0, 16'h0CF8, 4'hF, 0);                       // R1 readback 0

    // R2 masking, R3 partial write ignored
    access(1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF);
    access(0, 16'h0CF8, 4'hF, 0);
    access(1, 16'h0CF8, 4'b0111, 32'h0000_0000);        // R3
    chk(mdl_cfg == 32'h80FF_FFFC, "R3", "model unchanged", mdl_cfg, 32'h80FF_FFFC);
    access(0, 16'h0CF8, 4'hF, 0);                       // R3 readback at ports

    // directed routing corners
    set_cfg(1, 8'h00, 5'd0, 3'd1, 6'h04); access(0, 16'h0CFC, 4'hF, 0);       // R6
    set_cfg(1, 8'h00, 5'd1, 3'd0, 6'h10); access(1, 16'h0CFC, 4'h3, 32'h1234); // R5
    set_cfg(1, 8'h00, 5'd2, 3'd0, 6'h00); access(0, 16'h0CFC, 4'hF, 0);       // R7 disabled
    set_cfg(1, 8'h00, 5'd9, 3'd7, 6'h3F); access(0, 16'h0CFC, 4'hF, 0);       // R7 external
    set_cfg(1, 8'd2, 5'd3, 3'd0, 6'h01); access(0, 16'h0CFC, 4'hF, 0);        // R8 type0
    set_cfg(1, 8'd5, 5'd3, 3'd0, 6'h01); access(1, 16'h0CFC, 4'hF, 32'hA5A5); // R8 type1
    set_cfg(1, 8'd6, 5'd0, 3'd0, 6'h00); access(0, 16'h0CFC, 4'hF, 0);        // R9
    set_cfg(0, 8'd3, 5'd0, 3'd0, 6'h00); access(0, 16'h0CFC, 4'hF, 0);        // R4
    access(1, 16'h0080, 4'h1, 32'h55);                                         // R12

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0) begin
        dev_en = 4'($urandom);
        sec_bus = 8'($urandom_range(1, 12));
        sub_bus = sec_bus + 8'($urandom_range(0, 4)) - 8'($urandom_range(0, 1));
      end
      if (sel <= 4) begin
        set_cfg($urandom_range(0, 4) != 0, pick_bus(), 5'($urandom_range(0, 7)),
                3'($urandom), 6'($urandom));
        for (int k = 0; k < 2; k++)
          access($urandom_range(0, 1), 16'h0CFC, 4'($urandom), $urandom);
      end else if (sel == 5) begin
        access(1, 16'h0CF8, 4'($urandom_range(0, 14)), $urandom);   // R3 partial
        access(0, 16'h0CF8, 4'hF, 0);
      end else if (sel == 6) begin
        logic [15:0] a = 16'($urandom) & 16'hFFFC;
        if (a[15:3] == 13'h019F) a = 16'h0084;
        access($urandom_range(0, 1), a, 4'($urandom), $urandom);    // R12
      end else begin
        access($urandom_range(0, 1), 16'h0CFC, 4'($urandom), $urandom);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule